// File: doc/BRIEF.md
# PHY Power Control Register Bank

This block is a small 32-bit register file that controls a PHY's power-up and calibration sequence. Software writes it over a simple synchronous bus. A write never needs a read first, because the upper half of every write word is a per-bit write enable for the lower half. When an enable bit is set, the matching stored bit takes the new value. When it is clear, the stored bit keeps its value. This lets software switch the power enable or the DLL enable in one write without disturbing the other bits of the register.

The bank holds seven 16-bit control registers and one read-only status word. The last control register drives two PHY pins: the power enable and the DLL enable. The status word reports the PHY's calibration-done and DLL-ready inputs, which are registered once on every clock. Reads are registered, so read data arrives one cycle after the read strobe.

Top module: `phy_ctl_regbank`

## Requirements
- R1: After synchronous reset, all seven control registers read 0, `phy_pwr_en_o` and `phy_dll_en_o` are 0, and `bus_rdata` is 0.
- R2: On a write to a control register, stored bit x (0..15) takes `bus_wdata[x]` only when `bus_wdata[x+16]` is 1. Every other stored bit keeps its value.
- R3: The control registers sit at byte addresses 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18. Each is written and read independently of the others.
- R4: A read of a control register returns its 16 stored bits in `bus_rdata[15:0]`, with `bus_rdata[31:16]` equal to 0.
- R5: `phy_pwr_en_o` equals bit 0 and `phy_dll_en_o` equals bit 1 of the control register at 0x18 (1 = on/enabled). Both change on the clock edge that performs the write.
- R6: A read of address 0x20 returns `phy_cal_done_i` in bit 6 and `phy_dll_ready_i` in bit 5, with all other bits 0. The inputs pass through one register before the read captures them.
- R7: Writes to 0x20, to any address above 0x20, to 0x1C, or to any address whose two low bits are not 00 change no state. Reads of such addresses return 0; only 0x20 itself returns status.
- R8: `bus_rdata` is loaded on the clock edge that samples `bus_rd` and holds until the next read. A read and a write to the same register in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data: [31:16] per-bit enables, [15:0] values |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Registered read data |
| phy_cal_done_i | input | 1 | PHY calibration complete |
| phy_dll_ready_i | input | 1 | PHY DLL locked and ready |
| phy_pwr_en_o | output | 1 | PHY power-up enable |
| phy_dll_en_o | output | 1 | PHY DLL enable |

## Verification
Control register contents and the two PHY enables change on the write edge, so the bench checks them at the falling edge right after that edge. Read data is due at the falling edge after the edge that samples the read strobe. The monitor pops one expected word per read at exactly that point, from a queue that the read task fills. Status inputs take one extra edge to reach the status word, so the bench holds them for at least two cycles before it reads them. A combined read and write checks that the returned word is the value from before the write.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int HALF_W    = DATA_W / 2;
    localparam int NUM_CTRL  = 7;
    localparam int IDX_W     = $clog2(NUM_CTRL);
    localparam int WORD_AW   = ADDR_W - 2;

    // index of the register that drives the PHY pins
    localparam int PWR_REG_IDX = 6;
    localparam int PWR_BIT     = 0;
    localparam int DLL_EN_BIT  = 1;

    localparam logic [ADDR_W-1:0] STATUS_ADDR = 8'h20;
    localparam int CAL_DONE_BIT  = 6;
    localparam int DLL_READY_BIT = 5;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_STATUS = 2'd2
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e          kind;
        logic [IDX_W-1:0]   idx;
    } decode_t;

    typedef struct packed {
        logic cal_done;
        logic dll_ready;
    } phy_status_t;

    // enable-masked update of a 16-bit register from a 32-bit write word
    function automatic logic [HALF_W-1:0] masked_update(
        input logic [HALF_W-1:0] cur,
        input logic [DATA_W-1:0] wd
    );
        logic [HALF_W-1:0] en;
        en = wd[DATA_W-1:HALF_W];
        return (cur & ~en) | (wd[HALF_W-1:0] & en);
    endfunction

endpackage

// File: rtl/phyreg_decode.sv
module phyreg_decode
    import phyreg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    logic [WORD_AW-1:0] word_idx;
    logic               aligned;

    assign word_idx = addr[ADDR_W-1:2];
    assign aligned  = (addr[1:0] == 2'b00);

    always_comb begin
        dec.kind = SEL_NONE;
        dec.idx  = '0;
        if (aligned && (int'(word_idx) < NUM_CTRL)) begin
            dec.kind = SEL_CTRL;
            dec.idx  = word_idx[IDX_W-1:0];
        end else if (addr == STATUS_ADDR) begin
            dec.kind = SEL_STATUS;
        end
    end
endmodule

// File: rtl/phyreg_mreg.sv
module phyreg_mreg
    import phyreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [HALF_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= masked_update(q, wdata);
    end
endmodule

// File: rtl/phyreg_status.sv
module phyreg_status
    import phyreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cal_done_i,
    input  logic              dll_ready_i,
    output logic [DATA_W-1:0] status_word
);
    phy_status_t st_q;

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else begin
            st_q.cal_done  <= cal_done_i;
            st_q.dll_ready <= dll_ready_i;
        end
    end

    always_comb begin
        status_word                = '0;
        status_word[CAL_DONE_BIT]  = st_q.cal_done;
        status_word[DLL_READY_BIT] = st_q.dll_ready;
    end
endmodule

// File: rtl/phy_ctl_regbank.sv
module phy_ctl_regbank
    import phyreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic              phy_cal_done_i,
    input  logic              phy_dll_ready_i,
    output logic              phy_pwr_en_o,
    output logic              phy_dll_en_o
);
    decode_t           dec;
    logic [HALF_W-1:0] ctrl_q [NUM_CTRL];
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] rd_mux;

    phyreg_decode u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
        logic we_i;
        assign we_i = bus_wr && (dec.kind == SEL_CTRL) && (int'(dec.idx) == i);
        phyreg_mreg u_reg (
            .clk   (clk),
            .rst   (rst),
            .we    (we_i),
            .wdata (bus_wdata),
            .q     (ctrl_q[i])
        );
    end

    phyreg_status u_stat (
        .clk         (clk),
        .rst         (rst),
        .cal_done_i  (phy_cal_done_i),
        .dll_ready_i (phy_dll_ready_i),
        .status_word (status_word)
    );

    always_comb begin
        case (dec.kind)
            SEL_CTRL:   rd_mux = {{HALF_W{1'b0}}, ctrl_q[dec.idx]};
            SEL_STATUS: rd_mux = status_word;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    assign phy_pwr_en_o = ctrl_q[PWR_REG_IDX][PWR_BIT];
    assign phy_dll_en_o = ctrl_q[PWR_REG_IDX][DLL_EN_BIT];
endmodule

// File: rtl/phyreg_chk.sv
module phyreg_chk (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [31:0] bus_rdata,
    input logic        phy_pwr_en_o,
    input logic        phy_dll_en_o
);
    logic is_pwr_reg, is_ctrl, is_status;
    assign is_pwr_reg = (bus_addr == 8'h18);
    assign is_ctrl    = (bus_addr[1:0] == 2'b00) && (bus_addr <= 8'h18);
    assign is_status  = (bus_addr == 8'h20);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!phy_pwr_en_o && !phy_dll_en_o && bus_rdata == 32'h0)); // R1

    AST_MASK_HOLD_PWR: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_wdata[16]) |=> $stable(phy_pwr_en_o)); // R2

    AST_PWR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && is_pwr_reg && bus_wdata[16]) |=> (phy_pwr_en_o == $past(bus_wdata[0]))); // R5

    AST_DLL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && is_pwr_reg && bus_wdata[17]) |=> (phy_dll_en_o == $past(bus_wdata[1]))); // R5

    AST_OTHER_WR_NO_PIN: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !is_pwr_reg) |=> ($stable(phy_pwr_en_o) && $stable(phy_dll_en_o))); // R7

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && is_ctrl) |=> (bus_rdata[31:16] == 16'h0)); // R4

    AST_STATUS_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && is_status) |=> (bus_rdata[31:7] == 25'h0 && bus_rdata[4:0] == 5'h0)); // R6

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !is_ctrl && !is_status) |=> (bus_rdata == 32'h0)); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata)); // R8
endmodule

bind phy_ctl_regbank phyreg_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .phy_pwr_en_o (phy_pwr_en_o),
    .phy_dll_en_o (phy_dll_en_o)
);

// File: tb/phy_ctl_regbank_tb.sv
`timescale 1ns/1ps
module phy_ctl_regbank_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        cal_done = 1'b0;
    logic        dll_ready = 1'b0;
    logic        pwr_en, dll_en;

    always #4 clk = ~clk;

    phy_ctl_regbank u_dut (
        .clk             (clk),
        .rst             (rst),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .bus_wr          (bus_wr),
        .bus_rd          (bus_rd),
        .bus_rdata       (bus_rdata),
        .phy_cal_done_i  (cal_done),
        .phy_dll_ready_i (dll_ready),
        .phy_pwr_en_o    (pwr_en),
        .phy_dll_en_o    (dll_en)
    );

    typedef struct {
        logic [31:0] exp;
        string       req;
    } sb_item_t;

    sb_item_t    sbq[$];
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 0;
    logic [15:0] model [7];
    logic        rd_seen = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // independent per-bit model of an enable-masked write
    function automatic logic [15:0] model_write(input logic [15:0] cur, input logic [31:0] wd);
        logic [15:0] r;
        r = cur;
        for (int b = 0; b < 16; b++)
            if (wd[b + 16]) r[b] = wd[b];
        return r;
    endfunction

    function automatic bit is_ctrl_addr(input logic [7:0] a);
        return (a[1:0] == 2'b00) && (a <= 8'h18);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        if (is_ctrl_addr(a)) model[a[4:2]] = model_write(model[a[4:2]], d);
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        sb_item_t it;
        @(posedge clk); #1;
        it.exp = exp; it.req = req;
        sbq.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    // read and write in the same cycle; the read returns the old value
    task automatic rw(input logic [7:0] a, input logic [31:0] d, input string req);
        sb_item_t it;
        @(posedge clk); #1;
        it.exp = {16'h0, model[a[4:2]]}; it.req = req;
        sbq.push_back(it);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b1;
        model[a[4:2]] = model_write(model[a[4:2]], d);
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic drain;
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_pins(input string req);
        @(negedge clk);
        check(req, {30'h0, dll_en, pwr_en}, {30'h0, model[6][1], model[6][0]});
    endtask

    // monitor: read data is due at the negedge after the sampling posedge
    always @(posedge clk) rd_seen <= bus_rd && !rst;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sbq.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R8: actual %h expected <none queued>", bus_rdata);
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                check(it.req, bus_rdata, it.exp);
            end
        end
    end

    initial begin
        for (int i = 0; i < 7; i++) model[i] = '0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1", {30'h0, dll_en, pwr_en}, 32'h0);
        check("R1", bus_rdata, 32'h0);
        for (int i = 0; i < 7; i++) rd(8'(i * 4), 32'h0, "R1");
        drain();

        // full-enable writes with distinct patterns per register
        for (int i = 0; i < 7; i++) wr(8'(i * 4), {16'hFFFF, 16'hA5C0 ^ 16'(i * 16'h1111)});
        for (int i = 0; i < 7; i++) rd(8'(i * 4), {16'h0, model[i]}, "R3");
        drain();

        // partial masks
        wr(8'h08, {16'h00F0, 16'h0000});
        rd(8'h08, {16'h0, model[2]}, "R2");
        wr(8'h0C, {16'h0000, 16'hFFFF});
        rd(8'h0C, {16'h0, model[3]}, "R2");
        wr(8'h10, {16'h8001, 16'hFFFF});
        rd(8'h10, {16'h0, model[4]}, "R2");
        wr(8'h14, {16'hFFFF, 16'hFFFF});
        rd(8'h14, 32'h0000FFFF, "R4");
        drain();

        // PHY pins from register at 0x18
        wr(8'h18, {16'hFFFF, 16'h0000});
        check_pins("R5");
        wr(8'h18, {16'h0001, 16'h0001});
        check_pins("R5");
        wr(8'h18, {16'h0002, 16'h0002});
        check_pins("R5");
        wr(8'h18, {16'h0001, 16'h0000});
        check_pins("R5");
        wr(8'h18, {16'h0000, 16'h0003});
        check_pins("R5");

        // status sampling
        cal_done = 1'b1; dll_ready = 1'b0;
        repeat (2) @(posedge clk);
        rd(8'h20, 32'h0000_0040, "R6");
        cal_done = 1'b1; dll_ready = 1'b1;
        repeat (2) @(posedge clk);
        rd(8'h20, 32'h0000_0060, "R6");
        cal_done = 1'b0; dll_ready = 1'b1;
        repeat (2) @(posedge clk);
        rd(8'h20, 32'h0000_0020, "R6");
        drain();

        // ignored writes and unmapped reads
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, 32'h0000_0020, "R7");
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h05, 32'hFFFF_0000);
        wr(8'h1A, 32'hFFFF_FFFF);
        for (int i = 0; i < 7; i++) rd(8'(i * 4), {16'h0, model[i]}, "R7");
        rd(8'h1C, 32'h0, "R7");
        rd(8'h40, 32'h0, "R7");
        rd(8'h21, 32'h0, "R7");
        drain();
        check_pins("R7");

        // read during write, then hold
        rw(8'h04, {16'hFFFF, 16'h1234}, "R8");
        rd(8'h04, 32'h0000_1234, "R8");
        drain();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", bus_rdata, 32'h0000_1234);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule